// File: doc/BRIEF.md
# Single-wire bus master engine

This block is the timing engine on the master side of a single-wire, open-drain bus. It accepts one command at a time through a start/busy/done handshake. The commands are a bus reset with presence detection, a write slot carrying one bit, a read slot that returns one bit, and a strong-pullup phase. The block drives two enables to the pad logic: a pulldown enable, which pulls the line low, and a strong-pullup enable, which drives the line actively high. It watches the line through an internal synchronizer.

All durations are counted in ticks of a 1 µs enable input, so the system clock frequency has no effect on the bus timing. A reset holds the line low for 500 µs, samples the line 70 µs after release, and finishes 500 µs after release. Write and read slots are 65 µs long and always begin with a low pulse. The strong-pullup phase has two lengths, selected by the command argument. The long phase suits a temperature conversion and the short one an EEPROM copy. Byte sequencing is left to the caller, who issues the pullup command straight after the last bit of the command that needs the energy.

Top module: `owire_master`

## Requirements
- R1: A start with cmd_i=2'b00 (bus reset) drives pd_en_o high for exactly RST_LOW_US ticks (default 500), then releases it.
- R2: During a reset, the line is sampled PRES_SAMPLE_US ticks (default 70) after release. presence_o becomes 1 if the line was low at that point and 0 if it was high. presence_o keeps this value until the next reset samples the line again.
- R3: A reset completes, with its done_o pulse, RST_WAIT_US ticks (default 500) after pd_en_o falls.
- R4: cmd_i=2'b01 with arg_i=1 (write one) drives pd_en_o high for W1_LOW_US ticks (default 6), inside a slot of SLOT_US ticks (default 65).
- R5: cmd_i=2'b01 with arg_i=0 (write zero) drives pd_en_o high for W0_LOW_US ticks (default 60), inside a slot of SLOT_US ticks.
- R6: cmd_i=2'b10 (read) drives pd_en_o high for RD_LOW_US ticks (default 6). At RD_SAMPLE_US ticks (default 15) it loads the line level into rbit_o (low reads 0), and it ends after SLOT_US ticks.
- R7: cmd_i=2'b11 (strong pullup) holds spu_en_o high for SPU_LONG_TICKS when arg_i=1 and for SPU_SHORT_TICKS when arg_i=0. It then returns the line to resistor idle, and pd_en_o stays low for the whole phase.
- R8: pd_en_o and spu_en_o are never high in the same cycle.
- R9: start_i is ignored while busy_o is high. The running command's outputs and duration are not affected.
- R10: busy_o rises in the cycle after an accepted start. done_o is a single-cycle pulse, and busy_o is already low in that same cycle.
- R11: Timing advances only on cycles where tick_i is high. With tick_i held low, the bus outputs hold.
- R12: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 µs timing enable |
| start_i | input | 1 | Command strobe, accepted only while idle |
| cmd_i | input | 2 | 00 reset, 01 write, 10 read, 11 strong pullup |
| arg_i | input | 1 | Write value, or long-phase select for the pullup command |
| bus_i | input | 1 | Raw line level |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| presence_o | output | 1 | Presence result of the last reset |
| rbit_o | output | 1 | Bit sampled by the last read slot |
| pd_en_o | output | 1 | Open-drain pulldown enable |
| spu_en_o | output | 1 | Strong-pullup drive enable |

## Verification
The bench measures each low and pullup duration by counting the ticks seen while the enable is high, so an off-by-one phase limit shows up as one tick too many or too few. A device model answers resets with a presence pulse and holds the line low during read slots. If the sample point is misplaced, the design reports a missing device or reads a 1 instead of a 0. A second start is injected during a running reset; a design that accepts it would cut the reset short or raise the pullup. Ticks are also stopped in the middle of a write-zero; a design that counts clocks rather than ticks would shorten the low pulse.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    CMD_RESET  = 2'b00,
    CMD_WRITE  = 2'b01,
    CMD_READ   = 2'b10,
    CMD_PULLUP = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LO,
    ST_RST_HI,
    ST_SLOT,
    ST_SPU
  } state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q_q <= RST_VAL;
        else         q_q <= d_i;
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      assign q_o = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/owm_tick_cnt.sv
module owm_tick_cnt #(
  parameter int CW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;

  assign cnt_o = cnt_q;

  // R11: no tick, no progress
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int CW              = 20,
  parameter int RST_LOW_US      = 500,
  parameter int PRES_SAMPLE_US  = 70,
  parameter int RST_WAIT_US     = 500,
  parameter int SLOT_US         = 65,
  parameter int W1_LOW_US       = 6,
  parameter int W0_LOW_US       = 60,
  parameter int RD_LOW_US       = 6,
  parameter int RD_SAMPLE_US    = 15,
  parameter int SPU_LONG_TICKS  = 750000,
  parameter int SPU_SHORT_TICKS = 10000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  cmd_e          cmd_i,
  input  logic          arg_i,
  input  logic          bus_s_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          presence_o,
  output logic          rbit_o,
  output logic          pd_en_o,
  output logic          spu_en_o
);
  localparam logic [CW-1:0] RST_LO_END = CW'(RST_LOW_US - 1);
  localparam logic [CW-1:0] RST_HI_END = CW'(RST_WAIT_US - 1);
  localparam logic [CW-1:0] SLOT_END   = CW'(SLOT_US - 1);
  localparam logic [CW-1:0] LONG_END   = CW'(SPU_LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_END  = CW'(SPU_SHORT_TICKS - 1);
  localparam logic [CW-1:0] PRES_PT    = CW'(PRES_SAMPLE_US - 1);
  localparam logic [CW-1:0] RD_PT      = CW'(RD_SAMPLE_US - 1);

  state_e        state_q, state_d;
  logic          wr_q, bit_q, long_q;
  logic          done_q, pres_q, rbit_q;
  logic [CW-1:0] end_val, low_len;
  logic          phase_end, pres_hit, rd_hit;

  always_comb begin
    unique case (state_q)
      ST_RST_LO: end_val = RST_LO_END;
      ST_RST_HI: end_val = RST_HI_END;
      ST_SLOT:   end_val = SLOT_END;
      ST_SPU:    end_val = long_q ? LONG_END : SHORT_END;
      default:   end_val = '0;
    endcase
  end

  assign phase_end = tick_i && (state_q != ST_IDLE) && (cnt_i == end_val);
  assign pres_hit  = tick_i && (state_q == ST_RST_HI) && (cnt_i == PRES_PT);
  assign rd_hit    = tick_i && (state_q == ST_SLOT) && !wr_q && (cnt_i == RD_PT);

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    if (state_q == ST_IDLE) begin
      clr_o = 1'b1;
      if (start_i) begin
        unique case (cmd_i)
          CMD_RESET:  state_d = ST_RST_LO;
          CMD_WRITE,
          CMD_READ:   state_d = ST_SLOT;
          default:    state_d = ST_SPU;
        endcase
      end
    end else if (phase_end) begin
      clr_o   = 1'b1;
      state_d = (state_q == ST_RST_LO) ? ST_RST_HI : ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      bit_q   <= 1'b0;
      long_q  <= 1'b0;
      done_q  <= 1'b0;
      pres_q  <= 1'b0;
      rbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= phase_end && (state_q != ST_RST_LO);
      if (state_q == ST_IDLE && start_i) begin
        wr_q   <= (cmd_i == CMD_WRITE);
        bit_q  <= arg_i;
        long_q <= arg_i;
      end
      if (pres_hit) pres_q <= !bus_s_i;
      if (rd_hit)   rbit_q <= bus_s_i;
    end
  end

  assign low_len    = wr_q ? (bit_q ? CW'(W1_LOW_US) : CW'(W0_LOW_US)) : CW'(RD_LOW_US);
  assign pd_en_o    = (state_q == ST_RST_LO) || ((state_q == ST_SLOT) && (cnt_i < low_len));
  assign spu_en_o   = (state_q == ST_SPU);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign presence_o = pres_q;
  assign rbit_o     = rbit_q;

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pd_en_o && spu_en_o));
  p_busy_after_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(wr_q) && $stable(bit_q) && $stable(long_q)));
  p_presence_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(presence_o));
endmodule

// File: rtl/owire_master.sv
module owire_master
  import owm_pkg::*;
#(
  parameter int RST_LOW_US      = 500,
  parameter int PRES_SAMPLE_US  = 70,
  parameter int RST_WAIT_US     = 500,
  parameter int SLOT_US         = 65,
  parameter int W1_LOW_US       = 6,
  parameter int W0_LOW_US       = 60,
  parameter int RD_LOW_US       = 6,
  parameter int RD_SAMPLE_US    = 15,
  parameter int SPU_LONG_TICKS  = 750000,
  parameter int SPU_SHORT_TICKS = 10000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [1:0] cmd_i,
  input  logic       arg_i,
  input  logic       bus_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       presence_o,
  output logic       rbit_o,
  output logic       pd_en_o,
  output logic       spu_en_o
);
  localparam int MAXV = imax(imax(imax(RST_LOW_US, RST_WAIT_US), SLOT_US),
                             imax(SPU_LONG_TICKS, SPU_SHORT_TICKS));
  localparam int CW   = $clog2(MAXV + 1);

  logic          bus_s, clr;
  logic [CW-1:0] cnt;

  owm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(bus_i), .q_o(bus_s)
  );

  owm_tick_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i, .cnt_o(cnt)
  );

  owm_ctrl #(
    .CW(CW), .RST_LOW_US(RST_LOW_US), .PRES_SAMPLE_US(PRES_SAMPLE_US),
    .RST_WAIT_US(RST_WAIT_US), .SLOT_US(SLOT_US), .W1_LOW_US(W1_LOW_US),
    .W0_LOW_US(W0_LOW_US), .RD_LOW_US(RD_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US),
    .SPU_LONG_TICKS(SPU_LONG_TICKS), .SPU_SHORT_TICKS(SPU_SHORT_TICKS)
  ) u_ctrl (
    .clk_i, .rst_ni, .tick_i, .start_i,
    .cmd_i(cmd_e'(cmd_i)), .arg_i, .bus_s_i(bus_s), .cnt_i(cnt),
    .clr_o(clr), .busy_o, .done_o, .presence_o, .rbit_o, .pd_en_o, .spu_en_o
  );
endmodule

// File: tb/tb_owire_master.sv
`timescale 1ns/1ps
module tb_owire_master;
  localparam int T_RLO = 500, T_PRES = 70, T_RWAIT = 500, T_SLOT = 65;
  localparam int T_W1 = 6, T_W0 = 60, T_RDL = 6, T_RDS = 15;
  localparam int T_LONG = 300, T_SHORT = 40;
  localparam int DIV = 3;

  logic clk = 0, rst_ni = 0, tick_i = 0, start_i = 0, arg_i = 0;
  logic [1:0] cmd_i = 0;
  logic bus_i, busy_o, done_o, presence_o, rbit_o, pd_en_o, spu_en_o;
  logic dev_low = 0;
  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign bus_i = !(pd_en_o || dev_low);

  owire_master #(.SPU_LONG_TICKS(T_LONG), .SPU_SHORT_TICKS(T_SHORT)) dut (
    .clk_i(clk), .rst_ni, .tick_i, .start_i, .cmd_i, .arg_i, .bus_i,
    .busy_o, .done_o, .presence_o, .rbit_o, .pd_en_o, .spu_en_o);

  // tick generator
  int div = 0;
  bit tick_pause = 0;
  always @(negedge clk) begin
    if (tick_pause) tick_i <= 0;
    else begin
      div    <= (div == DIV-1) ? 0 : div + 1;
      tick_i <= (div == DIV-1);
    end
  end

  // device model and duration meters
  bit dev_pres_en = 0, dev_zero = 0, pd_prev = 0;
  int dev_mode = 0, dev_cnt = 0, pd_run = 0;
  int meas_pd = 0, meas_spu = 0, meas_busy = 0, meas_hi = 0;
  always @(posedge clk) begin
    pd_prev <= pd_en_o;
    if (pd_en_o) begin if (tick_i) pd_run <= pd_run + 1; end
    else if (!pd_prev) pd_run <= 0;
    if (start_i && !busy_o) begin
      meas_pd <= 0; meas_spu <= 0; meas_busy <= 0; meas_hi <= 0;
    end else if (tick_i) begin
      if (pd_en_o)  meas_pd  <= meas_pd + 1;
      if (spu_en_o) meas_spu <= meas_spu + 1;
      if (busy_o)   meas_busy <= meas_busy + 1;
      if (busy_o && !pd_en_o && !spu_en_o) meas_hi <= meas_hi + 1;
    end
    case (dev_mode)
      0: begin
        dev_low <= 0;
        if (pd_prev && !pd_en_o && pd_run >= 400 && dev_pres_en) begin
          dev_mode <= 1; dev_cnt <= 0;
        end else if (!pd_prev && pd_en_o && dev_zero) begin
          dev_mode <= 3; dev_cnt <= 0; dev_low <= 1;
        end
      end
      1: if (tick_i) begin
        if (dev_cnt == 19) begin dev_mode <= 2; dev_cnt <= 0; dev_low <= 1; end
        else dev_cnt <= dev_cnt + 1;
      end
      2: if (tick_i) begin
        if (dev_cnt == 99) begin dev_mode <= 0; dev_low <= 0; end
        else dev_cnt <= dev_cnt + 1;
      end
      default: if (tick_i) begin
        if (dev_cnt == 29) begin dev_mode <= 0; dev_low <= 0; end
        else dev_cnt <= dev_cnt + 1;
      end
    endcase
  end

  // behavioural reference model
  int m_state = 0, m_t = 0;
  bit m_wr = 0, m_bit = 0, m_done = 0, m_pres = 0, m_rbit = 0;
  bit h0 = 1, h1 = 1;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_t = 0; m_done = 0; m_pres = 0; m_rbit = 0; h0 = 1; h1 = 1;
    end else begin
      bit bs;
      int lim;
      bs = h1; h1 = h0; h0 = bus_i;
      m_done = 0;
      case (m_state)
        0: if (start_i) begin
          m_t = 0; m_bit = arg_i; m_wr = (cmd_i == 2'b01);
          m_state = (cmd_i == 2'b00) ? 1 : (cmd_i == 2'b11) ? 4 : 3;
        end
        default: if (tick_i) begin
          lim = (m_state == 1) ? T_RLO : (m_state == 2) ? T_RWAIT :
                (m_state == 3) ? T_SLOT : (m_bit ? T_LONG : T_SHORT);
          if (m_state == 2 && m_t == T_PRES-1) m_pres = !bs;
          if (m_state == 3 && !m_wr && m_t == T_RDS-1) m_rbit = bs;
          if (m_t == lim-1) begin
            m_t = 0;
            if (m_state == 1) m_state = 2;
            else begin m_state = 0; m_done = 1; end
          end else m_t++;
        end
      endcase
    end
  end

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_ni && !finished) begin
    int lowlen;
    string rq;
    lowlen = m_wr ? (m_bit ? T_W1 : T_W0) : T_RDL;
    rq = (m_state == 1 || m_state == 2) ? "R1" : (m_state == 4) ? "R7" :
         !m_wr ? "R6" : (m_bit ? "R4" : "R5");
    checks++;
    if (pd_en_o !== (m_state == 1 || (m_state == 3 && m_t < lowlen)))
      fail(rq, "pd_en_o", pd_en_o, !pd_en_o);
    if (spu_en_o !== (m_state == 4)) fail("R7", "spu_en_o", spu_en_o, m_state == 4);
    if (busy_o !== (m_state != 0)) fail("R10", "busy_o", busy_o, m_state != 0);
    if (done_o !== m_done) fail("R10", "done_o", done_o, m_done);
    if (presence_o !== m_pres) fail("R2", "presence_o", presence_o, m_pres);
    if (rbit_o !== m_rbit) fail("R6", "rbit_o", rbit_o, m_rbit);
    if (pd_en_o && spu_en_o) fail("R8", "pd_en_o&spu_en_o", 1, 0);
  end

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic issue(input logic [1:0] c, input logic a);
    @(negedge clk); start_i = 1; cmd_i = c; arg_i = a;
    @(negedge clk); start_i = 0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    chk("R10", "busy at done", busy_o, 0);
    @(negedge clk);
    chk("R10", "done width", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "pd_en_o", pd_en_o, 0); chk("R12", "spu_en_o", spu_en_o, 0);
    chk("R12", "busy_o", busy_o, 0);   chk("R12", "done_o", done_o, 0);
    chk("R12", "presence_o", presence_o, 0); chk("R12", "rbit_o", rbit_o, 0);
    rst_ni = 1;
    repeat (4) @(negedge clk);

    // reset with a device present
    dev_pres_en = 1;
    issue(2'b00, 0);
    chk("R10", "busy after start", busy_o, 1);
    wait_done();
    chk("R1", "reset low ticks", meas_pd, T_RLO);
    chk("R3", "post-release ticks", meas_hi, T_RWAIT);
    chk("R2", "presence seen", presence_o, 1);

    // reset with no device
    dev_pres_en = 0;
    issue(2'b00, 0); wait_done();
    chk("R2", "presence absent", presence_o, 0);

    issue(2'b01, 1); wait_done();
    chk("R4", "write1 low", meas_pd, T_W1);
    chk("R4", "slot length", meas_busy, T_SLOT);
    issue(2'b01, 0); wait_done();
    chk("R5", "write0 low", meas_pd, T_W0);
    chk("R5", "slot length", meas_busy, T_SLOT);

    dev_zero = 1;
    issue(2'b10, 0); wait_done();
    chk("R6", "read zero", rbit_o, 0);
    dev_zero = 0;
    issue(2'b10, 0); wait_done();
    chk("R6", "read one", rbit_o, 1);
    chk("R6", "read low", meas_pd, T_RDL);
    chk("R6", "slot length", meas_busy, T_SLOT);

    issue(2'b11, 1); wait_done();
    chk("R7", "long pullup", meas_spu, T_LONG);
    chk("R7", "pd during pullup", meas_pd, 0);
    issue(2'b11, 0); wait_done();
    chk("R7", "short pullup", meas_spu, T_SHORT);

    // R9: start during a running reset
    issue(2'b00, 0);
    repeat (300) @(negedge clk);
    issue(2'b11, 1);
    wait_done();
    chk("R9", "reset low kept", meas_pd, T_RLO);
    chk("R9", "no pullup", meas_spu, 0);
    chk("R9", "reset length", meas_busy, T_RLO + T_RWAIT);

    // R11: tick pause inside a write-0 low pulse
    issue(2'b01, 0);
    repeat (10) @(negedge clk);
    tick_pause = 1;
    repeat (60) @(negedge clk);
    chk("R11", "pd held", pd_en_o, 1);
    chk("R11", "busy held", busy_o, 1);
    tick_pause = 0;
    wait_done();
    chk("R11", "low ticks", meas_pd, T_W0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule